// File: doc/BRIEF.md
# Triple-Input Bitwise Majority Voter with Sticky Minority Flags

This block merges three redundant copies of a data word, produced by three lock-stepped replicas of the same logic, into one output word. Each output bit takes the value that at least two of the three copies agree on. For each copy the block also records, bit by bit, where that copy was outvoted. Those records are sticky, so a status read taken once per telemetry frame shows every disagreement since the previous read. Beside each flag vector, an 8-bit saturating counter records how many clock cycles that copy was outvoted on at least one bit.

A single read-clear strobe from the slave bus empties all flags and counters. Two strap pins select the routing mode for bench testing. In the vote mode the majority is driven out. The three pass modes send one chosen copy straight to the output. No register and no internal path can change the mode. The mode is held in a small registered state machine whose states are ROUTE_VOTE, ROUTE_A, ROUTE_B and ROUTE_C. On every clock edge the machine moves from any state to the state that the strap pins encode, so the output follows a new strap value one cycle after it appears. After reset the state is ROUTE_VOTE.

Top module: `tmr_voter`

## Requirements
- R1: With mode ROUTE_VOTE active, every bit of `data_out` equals the 2-of-3 majority of the matching bits of `in_a`, `in_b` and `in_c`. The output is combinational from the inputs.
- R2: On a clock edge where one input's bit differs from the other two inputs' matching bits (which agree with each other), the matching bit of that input's flag vector (`err_a`, `err_b`, `err_c`) becomes 1 after that edge.
- R3: A flag bit, once set, stays set on every later edge where `rd_clr` is low. An edge with `rd_clr` high clears it.
- R4: If `rd_clr` is high in the same cycle as a new minority bit, that bit is 1 after the edge and all other flag bits are 0 (set wins over clear).
- R5: A copy's counter rises by exactly one on each edge where that copy is outvoted on one or more bits, regardless of how many bits.
- R6: The counters are 8 bits wide and saturate at 255.
- R7: An edge with `rd_clr` high sets each counter to 1 if its copy is outvoted in that cycle, and to 0 otherwise.
- R8: `strap_sel` encodes 2'b00 = vote, 2'b01 = pass `in_a`, 2'b10 = pass `in_b` and 2'b11 = pass `in_c`. A new strap value takes effect on `data_out` after the next clock edge.
- R9: Flags and counters keep updating while a pass mode is active.
- R10: While `rst_n` is low, and after it is released, the flags and counters are 0 and the mode is ROUTE_VOTE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 16 | Redundant copy A |
| in_b | input | 16 | Redundant copy B |
| in_c | input | 16 | Redundant copy C |
| strap_sel | input | 2 | Routing mode strap pins |
| rd_clr | input | 1 | Status read strobe; clears flags and counters |
| data_out | output | 16 | Voted or passed-through word |
| err_a | output | 16 | Sticky minority flags of copy A |
| err_b | output | 16 | Sticky minority flags of copy B |
| err_c | output | 16 | Sticky minority flags of copy C |
| cnt_a | output | 8 | Outvoted-cycle counter of copy A |
| cnt_b | output | 8 | Outvoted-cycle counter of copy B |
| cnt_c | output | 8 | Outvoted-cycle counter of copy C |

## Verification
Two functions can fall in the same cycle: the read-clear strobe and a fresh disagreement. The bench first leaves an old flag set on copy B. It then raises `rd_clr` in the same cycle that copy B is outvoted on a different bit. The test passes only if, after that edge, the old bit is gone, the new bit is set and copy B's counter reads 1. The bench makes a second pairing: it turns on a pass mode and outvotes a copy in the same cycle, then checks that the output follows the strap while the flag and counter still record the disagreement.

// File: rtl/tmr_vote_pkg.sv
`timescale 1ns/1ps
package tmr_vote_pkg;
    typedef enum logic [1:0] {
        ROUTE_VOTE = 2'b00,
        ROUTE_A    = 2'b01,
        ROUTE_B    = 2'b10,
        ROUTE_C    = 2'b11
    } route_e;

    localparam int NUM_COPIES = 3;
endpackage

// File: rtl/tmr_vote_core.sv
`timescale 1ns/1ps
module tmr_vote_core #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cp_a,
    input  logic [DATA_W-1:0] cp_b,
    input  logic [DATA_W-1:0] cp_c,
    output logic [DATA_W-1:0] maj,
    output logic [DATA_W-1:0] odd_a,
    output logic [DATA_W-1:0] odd_b,
    output logic [DATA_W-1:0] odd_c
);
    // A copy is outvoted on a bit when the other two agree with each other and differ from it.
    always_comb begin
        maj   = (cp_a & cp_b) | (cp_a & cp_c) | (cp_b & cp_c);
        odd_a = (cp_a ^ cp_b) & ~(cp_b ^ cp_c);
        odd_b = (cp_b ^ cp_a) & ~(cp_a ^ cp_c);
        odd_c = (cp_c ^ cp_a) & ~(cp_a ^ cp_b);
    end
endmodule

// File: rtl/tmr_route_fsm.sv
`timescale 1ns/1ps
module tmr_route_fsm
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_sel,
    input  logic [DATA_W-1:0] maj,
    input  logic [DATA_W-1:0] cp_a,
    input  logic [DATA_W-1:0] cp_b,
    input  logic [DATA_W-1:0] cp_c,
    output logic [DATA_W-1:0] data_out
);
    route_e state_q;
    route_e state_d;

    // Next state: the mode named by the strap pins, from any state.
    always_comb begin
        unique case (strap_sel)
            2'b01:   state_d = ROUTE_A;
            2'b10:   state_d = ROUTE_B;
            2'b11:   state_d = ROUTE_C;
            default: state_d = ROUTE_VOTE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ROUTE_VOTE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ROUTE_A:    data_out = cp_a;
            ROUTE_B:    data_out = cp_b;
            ROUTE_C:    data_out = cp_c;
            ROUTE_VOTE: data_out = maj;
            default:    data_out = maj;
        endcase
    end
endmodule

// File: rtl/tmr_err_track.sv
`timescale 1ns/1ps
module tmr_err_track #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_clr,
    input  logic [DATA_W-1:0] odd,
    output logic [DATA_W-1:0] flags_q,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic hit;
    assign hit = |odd;

    // A new disagreement is OR-ed in after the clear, so setting wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (rd_clr) begin
            flags_q <= odd;
        end else begin
            flags_q <= flags_q | odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_clr) begin
            cnt_q <= hit ? CNT_ONE : '0;
        end else if (hit && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/tmr_voter.sv
`timescale 1ns/1ps
module tmr_voter
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    input  logic [1:0]        strap_sel,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] err_a,
    output logic [DATA_W-1:0] err_b,
    output logic [DATA_W-1:0] err_c,
    output logic [CNT_W-1:0]  cnt_a,
    output logic [CNT_W-1:0]  cnt_b,
    output logic [CNT_W-1:0]  cnt_c
);
    logic [DATA_W-1:0] maj;
    logic [NUM_COPIES-1:0][DATA_W-1:0] odd_arr;
    logic [NUM_COPIES-1:0][DATA_W-1:0] flag_arr;
    logic [NUM_COPIES-1:0][CNT_W-1:0]  cnt_arr;

    tmr_vote_core #(.DATA_W(DATA_W)) u_core (
        .cp_a  (in_a),
        .cp_b  (in_b),
        .cp_c  (in_c),
        .maj   (maj),
        .odd_a (odd_arr[0]),
        .odd_b (odd_arr[1]),
        .odd_c (odd_arr[2])
    );

    tmr_route_fsm #(.DATA_W(DATA_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sel (strap_sel),
        .maj       (maj),
        .cp_a      (in_a),
        .cp_b      (in_b),
        .cp_c      (in_c),
        .data_out  (data_out)
    );

    for (genvar gi = 0; gi < NUM_COPIES; gi++) begin : g_track
        tmr_err_track #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_clr  (rd_clr),
            .odd     (odd_arr[gi]),
            .flags_q (flag_arr[gi]),
            .cnt_q   (cnt_arr[gi])
        );
    end

    assign err_a = flag_arr[0];
    assign err_b = flag_arr[1];
    assign err_c = flag_arr[2];
    assign cnt_a = cnt_arr[0];
    assign cnt_b = cnt_arr[1];
    assign cnt_c = cnt_arr[2];
endmodule

// File: rtl/tmr_voter_chk.sv
`timescale 1ns/1ps
module tmr_voter_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [DATA_W-1:0] in_c,
    input logic [1:0]        strap_sel,
    input logic              rd_clr,
    input logic [DATA_W-1:0] data_out,
    input logic [DATA_W-1:0] err_a,
    input logic [DATA_W-1:0] err_b,
    input logic [DATA_W-1:0] err_c,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b,
    input logic [CNT_W-1:0]  cnt_c
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [DATA_W-1:0] dis_a, dis_b, dis_c;
    assign dis_a = data_out ^ in_a;
    assign dis_b = data_out ^ in_b;
    assign dis_c = data_out ^ in_c;

    assert_vote_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && strap_sel == 2'b00 && $past(strap_sel) == 2'b00)
        |-> (((dis_a & dis_b) | (dis_a & dis_c) | (dis_b & dis_c)) == '0));

    assert_pass_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strap_sel) == 2'b01) |-> (data_out == in_a));

    assert_pass_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strap_sel) == 2'b11) |-> (data_out == in_c));

    assert_sticky_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((err_a & $past(err_a)) == $past(err_a)));

    assert_sticky_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((err_b & $past(err_b)) == $past(err_b)));

    assert_sticky_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((err_c & $past(err_c)) == $past(err_c)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && in_b == in_c && in_a != in_b) |=> (err_a != '0));

    assert_step_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1));

    assert_step_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 1'b1));

    assert_step_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (cnt_c == $past(cnt_c) || cnt_c == $past(cnt_c) + 1'b1));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && cnt_a == CMAX) |=> (cnt_a == CMAX));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && in_a == in_b && in_b == in_c) |=> (cnt_a == '0 && cnt_b == '0 && cnt_c == '0));
endmodule

bind tmr_voter tmr_voter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .strap_sel (strap_sel),
    .rd_clr    (rd_clr),
    .data_out  (data_out),
    .err_a     (err_a),
    .err_b     (err_b),
    .err_c     (err_c),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .cnt_c     (cnt_c)
);

// File: tb/tmr_voter_test.sv
`timescale 1ns/1ps
module tmr_voter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] in_a, in_b, in_c;
    logic [1:0]  strap_sel;
    logic        rd_clr;
    logic [15:0] data_out, err_a, err_b, err_c;
    logic [7:0]  cnt_a, cnt_b, cnt_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_voter uut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .strap_sel(strap_sel), .rd_clr(rd_clr), .data_out(data_out),
        .err_a(err_a), .err_b(err_b), .err_c(err_c),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c)
    );

    // {a, b, c, expected majority}
    localparam logic [63:0] VEC [6] = '{
        {16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF},
        {16'h1234, 16'h1234, 16'hFFFF, 16'h1234},
        {16'hF0F0, 16'h0F0F, 16'h00FF, 16'h00FF},
        {16'hAAAA, 16'h5555, 16'hAAAA, 16'hAAAA},
        {16'h0001, 16'h0002, 16'h0003, 16'h0003}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic clr);
        in_a = a; in_b = b; in_c = c; rd_clr = clr;
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; strap_sel = 2'b00;
        drive(16'h0, 16'h0, 16'h0, 1'b0);
        repeat (3) next();
        #1;
        check("R10 err_a in reset", err_a, 16'h0);
        check("R10 cnt_c in reset", {8'h0, cnt_c}, 16'h0);
        rst_n = 1'b1;
        next(); #1;
        check("R10 err_b after reset", err_b, 16'h0);
        check("R10 cnt_a after reset", {8'h0, cnt_a}, 16'h0);
        check("R10 vote mode after reset", data_out, 16'h0);

        // Vector table: majority output in vote mode
        for (int i = 0; i < 6; i++) begin
            drive(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], 1'b0);
            #1;
            check("R1 majority table", data_out, VEC[i][15:0]);
            next();
        end

        // Clear with agreeing inputs
        drive(16'h0, 16'h0, 16'h0, 1'b1); next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R3 clear err_a", err_a, 16'h0);
        check("R3 clear err_c", err_c, 16'h0);
        check("R7 clear cnt_b", {8'h0, cnt_b}, 16'h0);

        // Single-bit minority on copy A
        drive(16'h0001, 16'h0, 16'h0, 1'b0); next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R2 err_a bit0", err_a, 16'h0001);
        check("R2 err_b untouched", err_b, 16'h0);
        check("R5 cnt_a one hit", {8'h0, cnt_a}, 16'h0001);
        next(); #1;
        check("R3 err_a sticky", err_a, 16'h0001);
        check("R5 cnt_a no hit", {8'h0, cnt_a}, 16'h0001);

        // Read-clear in the same cycle as a new minority bit on copy B
        drive(16'h0, 16'h0001, 16'h0, 1'b0); next();
        drive(16'h0, 16'h8000, 16'h0, 1'b1); next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R4 err_b set wins", err_b, 16'h8000);
        check("R7 cnt_b same-cycle hit", {8'h0, cnt_b}, 16'h0001);
        check("R3 err_a cleared", err_a, 16'h0);
        check("R7 cnt_a cleared", {8'h0, cnt_a}, 16'h0);

        // Multi-bit minorities count one per cycle; flags accumulate
        drive(16'h0, 16'h0, 16'h0, 1'b1); next();
        drive(16'h0, 16'h0, 16'h00FF, 1'b0);
        repeat (5) next();
        drive(16'h0, 16'h0, 16'hFF00, 1'b0); next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R5 cnt_c per cycle", {8'h0, cnt_c}, 16'h0006);
        check("R3 err_c accumulates", err_c, 16'hFFFF);

        // Saturation
        drive(16'h0, 16'h0, 16'h0, 1'b1); next();
        drive(16'hFFFF, 16'h0, 16'h0, 1'b0);
        repeat (260) next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R6 cnt_a saturates", {8'h0, cnt_a}, 16'h00FF);
        next(); #1;
        check("R6 cnt_a holds", {8'h0, cnt_a}, 16'h00FF);
        drive(16'h0, 16'h0, 16'h0, 1'b1); next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R7 cnt_a cleared from max", {8'h0, cnt_a}, 16'h0);

        // Strap routing
        drive(16'h1111, 16'h2222, 16'h4444, 1'b0); #1;
        check("R1 vote distinct", data_out, 16'h0000);
        strap_sel = 2'b01; #1;
        check("R8 strap not yet active", data_out, 16'h0000);
        next(); #1;
        check("R8 pass A", data_out, 16'h1111);
        strap_sel = 2'b10; next(); #1;
        check("R8 pass B", data_out, 16'h2222);
        strap_sel = 2'b11; next(); #1;
        check("R8 pass C", data_out, 16'h4444);
        strap_sel = 2'b00; next(); #1;
        check("R8 back to vote", data_out, 16'h0000);

        // Flags still update in a pass mode
        strap_sel = 2'b01;
        drive(16'h0, 16'h0, 16'h0, 1'b1); next();
        drive(16'h0100, 16'h0, 16'h0, 1'b0); #1;
        check("R8 pass A live", data_out, 16'h0100);
        next();
        drive(16'h0, 16'h0, 16'h0, 1'b0); #1;
        check("R9 err_a in pass mode", err_a, 16'h0100);
        check("R9 cnt_a in pass mode", {8'h0, cnt_a}, 16'h0001);
        strap_sel = 2'b00;
        next();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule